// File: doc/BRIEF.md
# Dual Color Lookup Table Loader

This block holds two color lookup tables, each with `ENTRIES` words (256 by default) of `DATA_W` bits. Software fills a table with a short command stream. It first sends one address command that sets the table's fill position. Each data command that follows stores one word at that position and moves the position forward by one. A pixel pipeline reads either table at any time through a separate port, giving a table select and an entry index. The word comes back one cycle later.

Each table keeps its own fill position and its own sticky overflow flag. The flag reports a data command that arrives after the position has passed the last entry. That write is discarded. This lets software detect a load whose start index plus length exceeds the table size.

The command port uses valid/ready. `wr_ready` is held high at all times, so there is no back-pressure. A command is taken on every clock edge where `wr_valid` is high. The read port has no ready: the pixel side cannot stall, and `rd_data_valid` marks each returned word.

Top module: `lut_dual_loader`

## Requirements
- R1: After reset, both overflow flags are 0 and both fill positions are 0, so a data command issued before any address command lands in entry 0.
- R2: An accepted address command (`wr_is_data`=0) to table `wr_sel` sets that table's fill position to `wr_data[IDX_W-1:0]` and clears that table's overflow flag.
- R3: An accepted data command (`wr_is_data`=1) stores `wr_data` at the selected table's current position and then advances the position by one.
- R4: A data command that arrives when the position has reached `ENTRIES` changes no entry and sets the table's overflow flag. The flag stays set through further commands of any kind until the next address command to that table.
- R5: Commands to one table leave the other table's entries, position and overflow flag unchanged.
- R6: A read request (`rd_valid`=1, with `rd_sel` and `rd_index`) returns the addressed entry on `rd_data`, with `rd_data_valid`=1, exactly one cycle later. `rd_data_valid` is 0 in a cycle that follows no request.
- R7: When a read and a data write hit the same entry in the same cycle, the read returns the value held before the write.
- R8: `wr_ready` is 1 in every cycle after reset.
- R9: While `wr_valid` is 0, the command inputs have no effect on any table, position or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Command valid |
| wr_ready | output | 1 | Command ready, always high |
| wr_sel | input | TSEL_W | Table targeted by the command |
| wr_is_data | input | 1 | 0 = address command, 1 = data command |
| wr_data | input | DATA_W | Start index (low IDX_W bits) or entry word |
| rd_valid | input | 1 | Read request |
| rd_sel | input | TSEL_W | Table to read |
| rd_index | input | IDX_W | Entry to read |
| rd_data_valid | output | 1 | Read result valid, one cycle after request |
| rd_data | output | DATA_W | Read result |
| overflow | output | NUM_TABLES | Sticky overflow flag per table |

## Verification
The bench builds the block with `ENTRIES`=16 and `DATA_W`=16. At that size every entry of both tables can be loaded and read back in a few hundred cycles. Overflow at the end of a table is reached from start index 0 and from a mid-table start. Same-cycle read/write collisions and ignored commands can be checked on individual entries, with every expected word derived arithmetically from the table, index and pass number.

// File: rtl/lut_pkg.sv
package lut_pkg;
  typedef enum logic {
    CMD_ADDR = 1'b0,
    CMD_DATA = 1'b1
  } lut_cmd_e;
endpackage

// File: rtl/lut_index_ctrl.sv
module lut_index_ctrl #(
  parameter int ENTRIES = 256,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_wr,
  input  logic             data_wr,
  input  logic [IDX_W-1:0] addr_val,
  output logic             mem_we,
  output logic [IDX_W-1:0] mem_waddr,
  output logic             ovf
);
  localparam int PTR_W = IDX_W + 1;
  localparam logic [PTR_W-1:0] LIMIT = PTR_W'(ENTRIES);

  logic [PTR_W-1:0] ptr;
  logic             full;

  assign full      = (ptr >= LIMIT);
  assign mem_we    = data_wr && !full;
  assign mem_waddr = ptr[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      ovf <= 1'b0;
    end else if (addr_wr) begin
      ptr <= {1'b0, addr_val};
      ovf <= 1'b0;
    end else if (data_wr) begin
      if (full) ovf <= 1'b1;
      else      ptr <= ptr + 1'b1;
    end
  end

  // R2
  addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> (ptr == {1'b0, $past(addr_val)}) && !ovf);

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !addr_wr && ptr < LIMIT) |=> ptr == $past(ptr) + 1'b1);

  // R4
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !addr_wr && ptr >= LIMIT) |=> ovf && $stable(ptr));

  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !addr_wr) |=> ovf);
endmodule

// File: rtl/lut_store.sv
module lut_store #(
  parameter int ENTRIES = 256,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/lut_dual_loader.sv
module lut_dual_loader #(
  parameter int ENTRIES    = 256,
  parameter int DATA_W     = 32,
  parameter int NUM_TABLES = 2,
  parameter int IDX_W      = $clog2(ENTRIES),
  parameter int TSEL_W     = (NUM_TABLES > 1) ? $clog2(NUM_TABLES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_valid,
  output logic                  wr_ready,
  input  logic [TSEL_W-1:0]     wr_sel,
  input  logic                  wr_is_data,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  rd_valid,
  input  logic [TSEL_W-1:0]     rd_sel,
  input  logic [IDX_W-1:0]      rd_index,
  output logic                  rd_data_valid,
  output logic [DATA_W-1:0]     rd_data,
  output logic [NUM_TABLES-1:0] overflow
);
  import lut_pkg::*;

  logic              accept;
  lut_cmd_e          cmd;
  logic [DATA_W-1:0] tbl_rd [NUM_TABLES];
  logic [TSEL_W-1:0] rd_sel_q;

  assign wr_ready = 1'b1;
  assign accept   = wr_valid && wr_ready;
  assign cmd      = lut_cmd_e'(wr_is_data);

  for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tbl
    logic             hit;
    logic             we;
    logic [IDX_W-1:0] waddr;

    assign hit = accept && (wr_sel == TSEL_W'(t));

    lut_index_ctrl #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_wr   (hit && cmd == CMD_ADDR),
      .data_wr   (hit && cmd == CMD_DATA),
      .addr_val  (wr_data[IDX_W-1:0]),
      .mem_we    (we),
      .mem_waddr (waddr),
      .ovf       (overflow[t])
    );

    lut_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .DATA_W(DATA_W)) store_i (
      .clk   (clk),
      .we    (we),
      .waddr (waddr),
      .wdata (wr_data),
      .re    (rd_valid && rd_sel == TSEL_W'(t)),
      .raddr (rd_index),
      .rdata (tbl_rd[t])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_valid <= 1'b0;
      rd_sel_q      <= '0;
    end else begin
      rd_data_valid <= rd_valid;
      if (rd_valid) rd_sel_q <= rd_sel;
    end
  end

  assign rd_data = tbl_rd[rd_sel_q];

  // R6
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rd_data_valid);

  // R6
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !rd_data_valid);

  // R8
  always_ff @(posedge clk) begin
    if (rst_n) wr_ready_chk: assert (wr_ready);
  end

  // R9
  idle_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> $stable(overflow));
endmodule

// File: tb/lut_dual_loader_tb_top.sv
module lut_dual_loader_tb_top;
  localparam int N  = 16;
  localparam int DW = 16;
  localparam int IW = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic wr_valid = 0, wr_is_data = 0, rd_valid = 0;
  logic [0:0] wr_sel = 0, rd_sel = 0;
  logic [DW-1:0] wr_data = 0;
  logic [IW-1:0] rd_index = 0;
  logic wr_ready, rd_data_valid;
  logic [DW-1:0] rd_data;
  logic [1:0] overflow;

  int total = 0, bad = 0;
  logic [DW-1:0] model [2][N];
  bit done = 0;

  always #10 clk = ~clk;

  lut_dual_loader #(.ENTRIES(N), .DATA_W(DW), .NUM_TABLES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_is_data(wr_is_data), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_sel(rd_sel), .rd_index(rd_index),
    .rd_data_valid(rd_data_valid), .rd_data(rd_data), .overflow(overflow));

  function automatic logic [DW-1:0] fv(int t, int i, int k);
    return DW'((t + 1) * 4099 + i * 257 + k * 31);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(int t, bit is_data, logic [DW-1:0] d);
    @(negedge clk);
    wr_valid = 1; wr_sel = 1'(t); wr_is_data = is_data; wr_data = d;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic rd(int t, int i, string req);
    @(negedge clk);
    rd_valid = 1; rd_sel = 1'(t); rd_index = IW'(i);
    @(negedge clk);
    rd_valid = 0;
    chk(req, {31'd0, rd_data_valid}, 1);
    chk(req, rd_data, model[t][i]);
  endtask

  task automatic load(int t, int start, int cnt, int k);
    cmd(t, 0, DW'(start));
    for (int i = 0; i < cnt; i++) begin
      cmd(t, 1, fv(t, start + i, k));
      if (start + i < N) model[t][start + i] = fv(t, start + i, k);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state, R8 ready
    chk("R1", overflow, 0);
    chk("R8", wr_ready, 1);
    chk("R6", rd_data_valid, 0);
    // R1 data without address lands at entry 0
    cmd(0, 1, 16'hBEEF); model[0][0] = 16'hBEEF;
    rd(0, 0, "R1");
    // R3 full loads, both tables
    for (int t = 0; t < 2; t++) begin
      load(t, 0, N, 1);
      chk("R3", overflow[t], 0);
    end
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < N; i++) rd(t, i, "R3");
    // R4 extra write dropped, flag set
    cmd(0, 1, 16'h1234);
    chk("R4", overflow, 2'b01);
    cmd(0, 1, 16'h5678);
    rd(0, 0, "R4");
    rd(0, N - 1, "R4");
    // R5 address to other table keeps flag
    cmd(1, 0, 0);
    chk("R5", overflow, 2'b01);
    for (int i = 0; i < N; i++) rd(0, i, "R4");
    chk("R4", overflow, 2'b01);
    // R2 address clears
    cmd(0, 0, 5);
    chk("R2", overflow, 2'b00);
    cmd(0, 1, fv(0, 5, 2)); model[0][5] = fv(0, 5, 2);
    rd(0, 5, "R2");
    rd(0, 6, "R2");
    // R2 mid start, R4 at end
    load(1, 10, N - 10, 3);
    chk("R2", overflow, 2'b00);
    cmd(1, 1, 16'hAAAA);
    chk("R4", overflow, 2'b10);
    for (int i = 0; i < N; i++) rd(1, i, "R5");
    for (int i = 0; i < N; i++) rd(0, i, "R5");
    // R2 upper data bits ignored for address
    cmd(1, 0, 16'hFFF3);
    chk("R2", overflow, 2'b00);
    // R7 same-cycle read/write
    @(negedge clk);
    wr_valid = 1; wr_sel = 1; wr_is_data = 1; wr_data = 16'hC0DE;
    rd_valid = 1; rd_sel = 1; rd_index = 3;
    @(negedge clk);
    wr_valid = 0; rd_valid = 0;
    chk("R7", rd_data, model[1][3]);
    model[1][3] = 16'hC0DE;
    rd(1, 3, "R7");
    // R9 invalid commands ignored
    @(negedge clk);
    wr_valid = 0; wr_sel = 1; wr_is_data = 1; wr_data = 16'h9999;
    @(negedge clk);
    wr_is_data = 0; wr_data = 16'h0000;
    @(negedge clk);
    rd(1, 4, "R9");
    cmd(1, 1, fv(1, 4, 4)); model[1][4] = fv(1, 4, 4);
    rd(1, 4, "R9");
    chk("R9", overflow, 2'b00);
    for (int i = 0; i < N; i++) rd(1, i, "R9");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule